// File: doc/BRIEF.md
# Indirect Register Bank for a Network Controller

This block is the 16-bit control and status register bank of a network controller. Software reaches it through two word ports. A write to the selector port picks one of four internal registers. Reads and writes on the data port then go to the register that is currently picked. The byte address on the bus is shifted right by one to form the word offset. Offset 0 is the data port and offset 1 is the selector port.

Register 0 is the primary status and command word. It holds three kinds of bit:
- seven event flags, cleared by writing a one to them;
- two summary bits, worked out again on each write;
- an interrupt enable that takes the written value.

It also holds init, start and stop commands. These are resolved by priority: stop first, then init, then start. Registers 1 and 2 hold the low and high halves of a 32-bit pointer to the initialization block, and register 3 is plain storage. The receive and transmit ring engines raise their event flags through single-cycle set pulses. They read the run state (stopped, started, receiver on, transmitter on) from dedicated outputs. The bank drives a level interrupt line.

Top module: `nic_csr_bank`

## Requirements
- R1: Writes are taken on the rising clock edge while `bus_wr` is high. Word offset `bus_addr[2:1]` = 0 is the data port and 1 is the selector port. Any other offset reads 0 and a write to it changes nothing.
- R2: A write to the selector port is taken only if the value is below 4; otherwise the selection is kept. Reading the selector port returns the current selection, zero-extended to 16 bits.
- R3: A status-register write with bit 2 (stop) set leaves the register at exactly 0x0004, whatever the other bits of the written value.
- R4: In a write without stop, a 1 in any of bits 14..8 clears that event flag. The flags are: 14 babble, 13 collision error, 12 missed frame, 11 memory error, 10 receive event, 9 transmit event, 8 init done.
- R5: After every status write, bit 15 is the OR of bits 14..11. Bit 7 equals the OR of bits 14..8 at all times.
- R6: In a write without stop, bit 6 (interrupt enable) takes the written bit 6.
- R7: In a write without stop, written bit 0 sets bit 0 (init) and bit 8, and clears bit 2. If bit 0 is not written, written bit 1 sets bits 1 (start), 5 (receiver on) and 4 (transmitter on), and clears bit 2. Init wins over start, and bits not named here keep their value.
- R8: Writing register 1 loads `init_ptr[15:0]` and writing register 2 loads `init_ptr[31:16]`. Registers 1, 2 and 3 read back the value last written.
- R9: After reset the status register is 0x0004, the selection is 0, and registers 1 to 3 are 0.
- R10: `irq` is high exactly while status bits 7 and 6 are both set.
- R11: A high `rx_evt_set` sets bits 10 and 7, and a high `tx_evt_set` sets bits 9 and 7, one cycle later. A set pulse wins over a write-one clear of the same flag in the same cycle.
- R12: `stopped`, `started`, `rx_on` and `tx_on` show status bits 2, 1, 5 and 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe for the current bus cycle |
| bus_addr | input | 3 | Byte address of the access |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr`, combinational |
| rx_evt_set | input | 1 | Receive-event set pulse from the receive ring engine |
| tx_evt_set | input | 1 | Transmit-event set pulse from the transmit ring engine |
| irq | output | 1 | Level interrupt request |
| init_ptr | output | 32 | Initialization-block pointer |
| stopped | output | 1 | Stop state (status bit 2) |
| started | output | 1 | Start command state (status bit 1) |
| rx_on | output | 1 | Receiver enabled (status bit 5) |
| tx_on | output | 1 | Transmitter enabled (status bit 4) |

## Verification
Several properties are checked on every cycle:
- the stop write collapsing the status word to 0x0004;
- the interrupt summary always matching the event flags;
- write-one clears, the enable loading, and a set pulse overriding a clear;
- the selector filter;
- the pointer-half loads;
- the interrupt line after a stop or an enabled receive event.

Other behaviour shows only in the bench's scenarios: the exact status words after init/start sequences with mixed clears, whether init beats start, and that unused offsets read 0 and absorb writes without effect.

// File: rtl/nic_csr_pkg.sv
package nic_csr_pkg;

    localparam int DATA_W    = 16;
    localparam int NREG      = 4;
    localparam int IDX_W     = $clog2(NREG);
    localparam int PTR_W     = 2 * DATA_W;
    localparam int ADDR_W    = 3;
    localparam int WOFS_W    = ADDR_W - 1;

    localparam logic [WOFS_W-1:0] WOFS_DATA = WOFS_W'(0);
    localparam logic [WOFS_W-1:0] WOFS_SEL  = WOFS_W'(1);

    localparam logic [DATA_W-1:0] STAT_RESET = 16'h0004;
    localparam logic [DATA_W-1:0] EVT_MASK   = 16'h7F00;
    localparam logic [DATA_W-1:0] ERR_MASK   = 16'h7800;

    typedef enum logic [IDX_W-1:0] {
        IDX_STATUS = 2'd0,
        IDX_PTR_LO = 2'd1,
        IDX_PTR_HI = 2'd2,
        IDX_SPARE  = 2'd3
    } reg_idx_e;

    // Status word, MSB first
    typedef struct packed {
        logic err_sum;   // 15
        logic babble;    // 14
        logic coll_err;  // 13
        logic missed;    // 12
        logic mem_err;   // 11
        logic rx_evt;    // 10
        logic tx_evt;    // 9
        logic init_done; // 8
        logic int_sum;   // 7
        logic int_en;    // 6
        logic rx_run;    // 5
        logic tx_run;    // 4
        logic tx_poll;   // 3
        logic halt;      // 2
        logic go;        // 1
        logic boot;      // 0
    } stat_t;

    // Next status word after a software write of v
    function automatic stat_t stat_after_write(stat_t cur, logic [DATA_W-1:0] v);
        stat_t              n;
        logic [DATA_W-1:0]  b;
        if (v[2]) begin
            n = stat_t'(STAT_RESET);
        end else begin
            b = cur & ~(v & EVT_MASK);
            n = stat_t'(b);
            n.int_en = v[6];
            if (v[0]) begin
                n.boot      = 1'b1;
                n.init_done = 1'b1;
                n.halt      = 1'b0;
            end else if (v[1]) begin
                n.go     = 1'b1;
                n.rx_run = 1'b1;
                n.tx_run = 1'b1;
                n.halt   = 1'b0;
            end
            b = n;
            n.err_sum = |(b & ERR_MASK);
            n.int_sum = |(b & EVT_MASK);
        end
        return n;
    endfunction

    // Engine set pulses applied on top of any write result
    function automatic stat_t stat_apply_events(stat_t s, logic rx, logic tx);
        stat_t n;
        n = s;
        if (rx) begin
            n.rx_evt  = 1'b1;
            n.int_sum = 1'b1;
        end
        if (tx) begin
            n.tx_evt  = 1'b1;
            n.int_sum = 1'b1;
        end
        return n;
    endfunction

endpackage

// File: rtl/nic_csr_index.sv
module nic_csr_index
    import nic_csr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic [DATA_W-1:0] wdata,
    output logic [IDX_W-1:0]  sel
);

    logic accept;
    assign accept = wr && (wdata < DATA_W'(NREG));

    always_ff @(posedge clk) begin
        if (rst) begin
            sel <= '0;
        end else if (accept) begin
            sel <= wdata[IDX_W-1:0];
        end
    end

    AST_SEL_FILTER: assert property (@(posedge clk) disable iff (rst)
        (wr && wdata >= DATA_W'(NREG)) |=> $stable(sel)) else $error("selector filter"); // R2
    AST_SEL_LOAD: assert property (@(posedge clk) disable iff (rst)
        (wr && wdata < DATA_W'(NREG)) |=> sel == $past(wdata[IDX_W-1:0])) else $error("selector load"); // R2

endmodule

// File: rtl/nic_csr_status.sv
module nic_csr_status
    import nic_csr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              rx_set,
    input  logic              tx_set,
    output stat_t             stat
);

    stat_t after_wr;
    stat_t nxt;

    always_comb begin
        after_wr = wr ? stat_after_write(stat, wdata) : stat;
        nxt      = stat_apply_events(after_wr, rx_set, tx_set);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            stat <= stat_t'(STAT_RESET);
        end else begin
            stat <= nxt;
        end
    end

    AST_STOP_EXACT: assert property (@(posedge clk) disable iff (rst)
        (wr && wdata[2] && !rx_set && !tx_set) |=> (stat == stat_t'(STAT_RESET))) else $error("stop write"); // R3
    AST_INT_SUMMARY: assert property (@(posedge clk) disable iff (rst)
        stat.int_sum == (|(stat & EVT_MASK))) else $error("interrupt summary"); // R5
    AST_W1C_IDONE: assert property (@(posedge clk) disable iff (rst)
        (wr && !wdata[2] && wdata[8] && !wdata[0]) |=> !stat.init_done) else $error("w1c"); // R4
    AST_EN_LOAD: assert property (@(posedge clk) disable iff (rst)
        (wr && !wdata[2]) |=> stat.int_en == $past(wdata[6])) else $error("enable load"); // R6
    AST_RX_PULSE_WINS: assert property (@(posedge clk) disable iff (rst)
        rx_set |=> (stat.rx_evt && stat.int_sum)) else $error("rx pulse"); // R11
    AST_TX_PULSE_WINS: assert property (@(posedge clk) disable iff (rst)
        tx_set |=> (stat.tx_evt && stat.int_sum)) else $error("tx pulse"); // R11

endmodule

// File: rtl/nic_csr_store.sv
module nic_csr_store
    import nic_csr_pkg::*;
(
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         wr,
    input  logic [IDX_W-1:0]             sel,
    input  logic [DATA_W-1:0]            wdata,
    output logic [(NREG-1)*DATA_W-1:0]   words,
    output logic [PTR_W-1:0]             ptr
);

    for (genvar g = 1; g < NREG; g++) begin : g_word
        logic [DATA_W-1:0] q;
        always_ff @(posedge clk) begin
            if (rst) begin
                q <= '0;
            end else if (wr && sel == IDX_W'(g)) begin
                q <= wdata;
            end
        end
        assign words[(g-1)*DATA_W +: DATA_W] = q;
    end

    assign ptr = {words[(int'(IDX_PTR_HI)-1)*DATA_W +: DATA_W],
                  words[(int'(IDX_PTR_LO)-1)*DATA_W +: DATA_W]};

    AST_PTR_LO_LOAD: assert property (@(posedge clk) disable iff (rst)
        (wr && sel == IDX_PTR_LO) |=> ptr[DATA_W-1:0] == $past(wdata)) else $error("ptr lo"); // R8
    AST_PTR_HI_LOAD: assert property (@(posedge clk) disable iff (rst)
        (wr && sel == IDX_PTR_HI) |=> ptr[PTR_W-1:DATA_W] == $past(wdata)) else $error("ptr hi"); // R8

endmodule

// File: rtl/nic_csr_bank.sv
module nic_csr_bank
    import nic_csr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic [2:0]        bus_addr,
    input  logic [15:0]       bus_wdata,
    output logic [15:0]       bus_rdata,
    input  logic              rx_evt_set,
    input  logic              tx_evt_set,
    output logic              irq,
    output logic [31:0]       init_ptr,
    output logic              stopped,
    output logic              started,
    output logic              rx_on,
    output logic              tx_on
);

    logic [WOFS_W-1:0]            wofs;
    logic                         wr_sel;
    logic                         wr_data;
    logic [IDX_W-1:0]             sel;
    stat_t                        stat;
    logic [(NREG-1)*DATA_W-1:0]   words;

    assign wofs    = bus_addr[ADDR_W-1:1];
    assign wr_sel  = bus_wr && (wofs == WOFS_SEL);
    assign wr_data = bus_wr && (wofs == WOFS_DATA);

    nic_csr_index u_index (
        .clk   (clk),
        .rst   (rst),
        .wr    (wr_sel),
        .wdata (bus_wdata),
        .sel   (sel)
    );

    nic_csr_status u_status (
        .clk    (clk),
        .rst    (rst),
        .wr     (wr_data && sel == IDX_STATUS),
        .wdata  (bus_wdata),
        .rx_set (rx_evt_set),
        .tx_set (tx_evt_set),
        .stat   (stat)
    );

    nic_csr_store u_store (
        .clk   (clk),
        .rst   (rst),
        .wr    (wr_data && sel != IDX_STATUS),
        .sel   (sel),
        .wdata (bus_wdata),
        .words (words),
        .ptr   (init_ptr)
    );

    always_comb begin
        bus_rdata = '0;
        if (wofs == WOFS_DATA) begin
            if (sel == IDX_STATUS) begin
                bus_rdata = stat;
            end else begin
                bus_rdata = words[(int'(sel)-1)*DATA_W +: DATA_W];
            end
        end else if (wofs == WOFS_SEL) begin
            bus_rdata = DATA_W'(sel);
        end
    end

    assign irq     = stat.int_sum && stat.int_en;
    assign stopped = stat.halt;
    assign started = stat.go;
    assign rx_on   = stat.rx_run;
    assign tx_on   = stat.tx_run;

    AST_IRQ_DROPS_ON_STOP: assert property (@(posedge clk) disable iff (rst)
        (wr_data && sel == IDX_STATUS && bus_wdata[2] && !rx_evt_set && !tx_evt_set) |=> !irq) else $error("irq stop"); // R10
    AST_IRQ_ON_RX: assert property (@(posedge clk) disable iff (rst)
        (rx_evt_set && stat.int_en && !wr_data) |=> irq) else $error("irq rx"); // R10

endmodule

// File: tb/sim_nic_csr_bank.sv
`timescale 1ns/1ps
module sim_nic_csr_bank;

    logic        clk = 1'b0;
    logic        rst;
    logic        bus_wr;
    logic [2:0]  bus_addr;
    logic [15:0] bus_wdata;
    logic [15:0] bus_rdata;
    logic        rx_evt_set;
    logic        tx_evt_set;
    logic        irq;
    logic [31:0] init_ptr;
    logic        stopped, started, rx_on, tx_on;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #2.5 clk = ~clk;

    nic_csr_bank u0 (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .rx_evt_set(rx_evt_set), .tx_evt_set(tx_evt_set), .irq(irq),
        .init_ptr(init_ptr), .stopped(stopped), .started(started),
        .rx_on(rx_on), .tx_on(tx_on)
    );

    typedef struct packed {
        logic        wr;
        logic [2:0]  adr;
        logic [15:0] dat;
        logic [15:0] exp;
        logic [3:0]  rq;
    } vec_t;

    localparam int NV = 25;
    localparam vec_t VEC [NV] = '{
        '{1'b0, 3'd2, 16'h0000, 16'h0000, 4'd9},  // R9 selection 0
        '{1'b0, 3'd0, 16'h0000, 16'h0004, 4'd9},  // R9 status reset
        '{1'b1, 3'd2, 16'h0005, 16'h0000, 4'd2},
        '{1'b0, 3'd2, 16'h0000, 16'h0000, 4'd2},  // R2 out of range ignored
        '{1'b1, 3'd2, 16'h0003, 16'h0000, 4'd2},
        '{1'b0, 3'd2, 16'h0000, 16'h0003, 4'd2},  // R2 accepted
        '{1'b1, 3'd0, 16'hBEEF, 16'h0000, 4'd8},
        '{1'b0, 3'd0, 16'h0000, 16'hBEEF, 4'd8},  // R8 spare storage
        '{1'b1, 3'd2, 16'h0001, 16'h0000, 4'd8},
        '{1'b1, 3'd0, 16'h1234, 16'h0000, 4'd8},
        '{1'b1, 3'd2, 16'h0002, 16'h0000, 4'd8},
        '{1'b1, 3'd0, 16'hABCD, 16'h0000, 4'd8},
        '{1'b0, 3'd0, 16'h0000, 16'hABCD, 4'd8},  // R8 readback
        '{1'b0, 3'd4, 16'h0000, 16'h0000, 4'd1},  // R1 unused offset reads 0
        '{1'b1, 3'd4, 16'h0003, 16'h0000, 4'd1},
        '{1'b0, 3'd2, 16'h0000, 16'h0002, 4'd1},  // R1 write to unused offset no effect
        '{1'b1, 3'd2, 16'h0000, 16'h0000, 4'd7},
        '{1'b1, 3'd0, 16'h0041, 16'h0000, 4'd7},
        '{1'b0, 3'd0, 16'h0000, 16'h01C1, 4'd7},  // R7 init, R5 summary, R6 enable
        '{1'b1, 3'd0, 16'h0002, 16'h0000, 4'd7},
        '{1'b0, 3'd0, 16'h0000, 16'h01B3, 4'd6},  // R6 enable cleared, R7 start
        '{1'b1, 3'd0, 16'h0143, 16'h0000, 4'd4},
        '{1'b0, 3'd0, 16'h0000, 16'h01F3, 4'd4},  // R4 clear then R7 init wins
        '{1'b1, 3'd0, 16'h0104, 16'h0000, 4'd3},
        '{1'b0, 3'd0, 16'h0000, 16'h0004, 4'd3}   // R3 stop collapses word
    };

    task automatic check(input logic [31:0] act, input logic [31:0] exp,
                         input int rq, input string what);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL R%0d %s actual=%h expected=%h", rq, what, act, exp);
        end
    endtask

    task automatic bus_write(input logic [2:0] a, input logic [15:0] d,
                             input logic rx, input logic tx);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        rx_evt_set = rx; tx_evt_set = tx;
        @(negedge clk);
        bus_wr = 1'b0; rx_evt_set = 1'b0; tx_evt_set = 1'b0;
    endtask

    task automatic pulse(input logic rx, input logic tx);
        @(negedge clk);
        rx_evt_set = rx; tx_evt_set = tx;
        @(negedge clk);
        rx_evt_set = 1'b0; tx_evt_set = 1'b0;
    endtask

    task automatic bus_read(input logic [2:0] a, output logic [15:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        summary();
    end

    initial begin
        logic [15:0] rd;
        rst = 1'b1; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
        rx_evt_set = 1'b0; tx_evt_set = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;

        check({31'd0, irq}, 32'd0, 9, "irq after reset");          // R9
        check(init_ptr, 32'd0, 9, "pointer after reset");           // R9
        check({31'd0, stopped}, 32'd1, 12, "stopped after reset");  // R12

        for (int i = 0; i < NV; i++) begin
            if (VEC[i].wr) begin
                bus_write(VEC[i].adr, VEC[i].dat, 1'b0, 1'b0);
                if (i == 17) check({31'd0, irq}, 32'd1, 10, "irq after init+enable"); // R10
                if (i == 19) check({31'd0, irq}, 32'd0, 10, "irq with enable off");   // R10
            end else begin
                bus_read(VEC[i].adr, rd);
                check({16'd0, rd}, {16'd0, VEC[i].exp}, int'(VEC[i].rq), $sformatf("vector %0d", i));
            end
            if (i == 11) check(init_ptr, 32'hABCD1234, 8, "pointer halves"); // R8
        end

        // R12 run state after stop, then start with enable
        check({28'd0, stopped, started, rx_on, tx_on}, 32'h8, 12, "run state stopped");
        bus_write(3'd0, 16'h0042, 1'b0, 1'b0);
        check({28'd0, stopped, started, rx_on, tx_on}, 32'h7, 12, "run state started");
        bus_read(3'd0, rd);
        check({16'd0, rd}, 32'h0072, 7, "start with enable");

        // R11 receive pulse sets flag and summary, raises irq
        pulse(1'b1, 1'b0);
        bus_read(3'd0, rd);
        check({16'd0, rd}, 32'h04F2, 11, "rx pulse");
        check({31'd0, irq}, 32'd1, 10, "irq on rx event");

        // R4 clear rx flag while tx pulse arrives
        bus_write(3'd0, 16'h0440, 1'b0, 1'b1);
        bus_read(3'd0, rd);
        check({16'd0, rd}, 32'h02F2, 4, "clear rx with tx pulse");

        // R11 pulse beats same-cycle clear
        bus_write(3'd0, 16'h0240, 1'b0, 1'b1);
        bus_read(3'd0, rd);
        check({16'd0, rd}, 32'h02F2, 11, "pulse wins over clear");

        // R5 summary drops when last flag cleared
        bus_write(3'd0, 16'h0240, 1'b0, 1'b0);
        bus_read(3'd0, rd);
        check({16'd0, rd}, 32'h0072, 5, "summary cleared");
        check({31'd0, irq}, 32'd0, 10, "irq low after clear");

        // R9 reset mid-run restores defaults
        @(negedge clk) rst = 1'b1;
        @(negedge clk) rst = 1'b0;
        bus_read(3'd0, rd);
        check({16'd0, rd}, 32'h0004, 9, "status after second reset");
        check(init_ptr, 32'd0, 9, "pointer after second reset");

        summary();
    end

endmodule